// File: doc/BRIEF.md
# Dual-Clock 18-bit FIFO with Fall-Through Option

This block is a first-in first-out buffer for 18-bit words. Its write side and its read side run on independent clocks. The depth is a power of two from 256 to 4096 words. A build-time parameter picks one of two ways of presenting data on the read side.

In standard presentation, a word stays inside the buffer until a read cycle moves it into the output register. In fall-through presentation, the oldest word is fetched into the output register on its own. It is then held there until a read cycle consumes it.

The write port works like a stream. A word is taken on a write-clock edge when the active-low write enable is low and the load input is high. The full indication is the back-pressure signal: while the buffer is full, an offered word is dropped and not stored, so the producer must watch that flag. The read port is also back-pressured, by the empty indication. A read request needs both the active-low read enable and the active-low output enable low, and a request made while nothing is stored has no effect. When the output enable is high, the data output is forced to zero and a separate data-enable output drops. This stands in for a released bus.

Every flag is active low. The polarity of the empty and full pins changes with the mode: in fall-through mode they mean "word ready" and "room available". The block also has a half-full flag and two programmable flags, almost-empty and almost-full. Their thresholds are written through the write data bus while the load input is held low.

Top module: `dc_fifo18`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted on the write port, all 18 bits unchanged.
- R2: A word is accepted on a rising `wr_clk` edge when `wr_en_n`=0, `load_n`=1 and the buffer is not full. An offered word while full is dropped, and the buffer still holds exactly the accepted words.
- R3: A read happens on a rising `rd_clk` edge only when `rd_en_n`=0 and `oe_n`=0. A read request while the buffer is empty is ignored, so the next word written is the next one read.
- R4: While `oe_n`=1, `rd_data` is 0 and `rd_data_en` is 0, and no word is consumed. When `oe_n` returns to 0, the previously presented word appears again.
- R5: Standard mode: `emp_ordy_n`=0 means empty. A word written into an empty buffer raises `emp_ordy_n` two `rd_clk` edges after the write edge, but `rd_data` changes only on the edge of a read cycle.
- R6: Fall-through mode: `emp_ordy_n`=0 means a word is on `rd_data`. A word written into an empty buffer appears, with `emp_ordy_n` going low, after the third `rd_clk` edge following the write edge, with no read enable. A read cycle consumes it.
- R7: The full indication is asserted when the storage array holds DEPTH words. In standard mode `full_irdy_n`=0 means full; in fall-through mode `full_irdy_n`=1 means full. In fall-through mode the output register holds one extra word, so DEPTH+1 words are accepted.
- R8: `half_n`=0 while the write-side count of stored words exceeds DEPTH/2.
- R9: `aempty_n`=0 while the read-side count is at most the almost-empty offset. In fall-through mode that count includes the output register. `afull_n`=0 while the write-side count is at least DEPTH minus the almost-full offset.
- R10: While `load_n`=0, each `wr_clk` edge with `wr_en_n`=0 stores `wr_data[AW-1:0]`. The first such edge stores the almost-empty offset and the second the almost-full offset, and the order then alternates. The order restarts when `load_n`=1, and load cycles store no data word.
- R11: After reset: the pointers are cleared, both offsets are 7, `rd_data` is 0, `half_n`=1, `aempty_n`=0 and `afull_n`=1. `emp_ordy_n` and `full_irdy_n` show empty and not full in the polarity of the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low offset load select |
| wr_data | input | 18 | Write data, or offset value during load |
| full_irdy_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| half_n | output | 1 | Active-low more-than-half-full flag |
| afull_n | output | 1 | Active-low almost-full flag |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_en_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | 18 | Read data, zero while output is disabled |
| rd_data_en | output | 1 | High when rd_data is driven |
| emp_ordy_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| aempty_n | output | 1 | Active-low almost-empty flag |

## Verification
The bench builds two copies at the smallest depth, 256: one in standard and one in fall-through presentation. Both are fed from one write stream. At that depth, filling to full, wrapping the pointers and overrunning the buffer all happen within a few hundred cycles. The extra word held in the fall-through output register can then be seen at the port. Both clocks come from one source, so the pointer-crossing delay is a fixed two edges. The reference model can therefore predict every flag and data word on every edge, including the three-edge fall-through latency and the alternating offset load.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W = 18;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {PRES_STD = 1'b0, PRES_FWFT = 1'b1} pres_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_gray2bin.sv
module dcf_gray2bin #(
  parameter int W = 9
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin[i] = ^(gray >> i);
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  dcf_pkg::word_t wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output dcf_pkg::word_t q
);
  localparam int ENTRIES = 1 << AW;

  dcf_pkg::word_t mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [AW-1:0] ld_data,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full,
  output logic          half,
  output logic          afull,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);
  localparam logic [AW-1:0] OFF_RST = AW'(7);

  logic [AW:0] wbin, wbin_nxt, rbin_s, cnt;
  logic        ld_sel;

  dcf_gray2bin #(.W(AW+1)) u_r2b (.gray(rgray_s), .bin(rbin_s));

  assign cnt      = wbin - rbin_s;
  assign full     = (cnt == DEPTH_V);
  assign we       = load_n & ~wr_en_n & ~full;
  assign wbin_nxt = wbin + {{AW{1'b0}}, we};
  assign waddr    = wbin[AW-1:0];
  assign half     = (cnt > HALF_V);
  assign afull    = (cnt >= (DEPTH_V - {1'b0, af_off}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= OFF_RST;
      af_off <= OFF_RST;
      ld_sel <= 1'b0;
    end else if (!load_n) begin
      if (!wr_en_n) begin
        if (!ld_sel) ae_off <= ld_data;
        else         af_off <= ld_data;
        ld_sel <= ~ld_sel;
      end
    end else begin
      ld_sel <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_V); // R7
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && load_n && !wr_en_n) |=> $stable(wbin)); // R2
  AST_LOAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> $stable(wbin)); // R10
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R1
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int            DEPTH = 256,
  parameter int            AW    = $clog2(DEPTH),
  parameter dcf_pkg::pres_e MODE = dcf_pkg::PRES_STD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          oe_n,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          ef_or_n,
  output logic          aempty
);
  logic [AW:0]   rbin, rbin_nxt, wbin_s, cnt;
  logic [AW+1:0] occ;
  logic          ram_empty, rd_req;

  dcf_gray2bin #(.W(AW+1)) u_w2b (.gray(wgray_s), .bin(wbin_s));

  assign cnt       = wbin_s - rbin;
  assign ram_empty = (cnt == '0);
  assign rd_req    = ~rd_en_n & ~oe_n;
  assign rbin_nxt  = rbin + {{AW{1'b0}}, re};
  assign raddr     = rbin[AW-1:0];
  assign aempty    = (occ <= {2'b00, ae_off});

  generate
    if (MODE == dcf_pkg::PRES_FWFT) begin : g_fwft
      logic ofull, consume;
      assign consume = ofull & rd_req;
      assign re      = ~ram_empty & (~ofull | consume);
      assign occ     = {1'b0, cnt} + {{(AW+1){1'b0}}, ofull};
      assign ef_or_n = ~ofull;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ofull <= 1'b0;
        else if (re)      ofull <= 1'b1;
        else if (consume) ofull <= 1'b0;
      end

      AST_OE_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && ofull) |=> ofull); // R4
    end else begin : g_std
      assign re      = rd_req & ~ram_empty;
      assign occ     = {1'b0, cnt};
      assign ef_or_n = ~ram_empty;

      AST_OE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> $stable(rbin)); // R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_empty |=> $stable(rbin)); // R3
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R1
endmodule

// File: rtl/dc_fifo18.sv
module dc_fifo18 #(
  parameter int             DEPTH = 256,
  parameter dcf_pkg::pres_e MODE  = dcf_pkg::PRES_STD
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic        wr_en_n,
  input  logic        load_n,
  input  logic [17:0] wr_data,
  output logic        full_irdy_n,
  output logic        half_n,
  output logic        afull_n,
  input  logic        rd_clk,
  input  logic        rd_rst_n,
  input  logic        rd_en_n,
  input  logic        oe_n,
  output logic [17:0] rd_data,
  output logic        rd_data_en,
  output logic        emp_ordy_n,
  output logic        aempty_n
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]    wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]  waddr, raddr, ae_off, af_off;
  logic           we, re, full, half, afull, aempty;
  dcf_pkg::word_t q;

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
    .ld_data(wr_data[AW-1:0]), .rgray_s(rgray_s), .wgray(wgray),
    .waddr(waddr), .we(we), .full(full), .half(half), .afull(afull),
    .ae_off(ae_off), .af_off(af_off)
  );

  dcf_sync #(.W(AW+1)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_sync #(.W(AW+1)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .AW(AW), .MODE(MODE)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .wgray_s(wgray_s), .ae_off(ae_off), .rgray(rgray), .raddr(raddr),
    .re(re), .ef_or_n(emp_ordy_n), .aempty(aempty)
  );

  dcf_ram #(.AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rst_n(rd_rst_n), .re(re), .raddr(raddr), .q(q)
  );

  generate
    if (MODE == dcf_pkg::PRES_FWFT) begin : g_ir
      assign full_irdy_n = full;
    end else begin : g_ff
      assign full_irdy_n = ~full;
    end
  endgenerate

  assign half_n     = ~half;
  assign afull_n    = ~afull;
  assign aempty_n   = ~aempty;
  assign rd_data_en = ~oe_n;
  assign rd_data    = oe_n ? '0 : q;
endmodule

// File: tb/dc_fifo18_bench.sv
module dc_fifo18_bench;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n, wr_en_n, load_n, oe_n, ren_s, ren_f;
  logic [17:0] wr_data;
  logic        full_s, half_s, af_s, emp_s, ae_s, den_s;
  logic        full_f, half_f, af_f, emp_f, ae_f, den_f;
  logic [17:0] data_s, data_f;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dc_fifo18 #(.DEPTH(DEPTH), .MODE(dcf_pkg::PRES_STD)) u_dc_fifo18 (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
    .wr_data(wr_data), .full_irdy_n(full_s), .half_n(half_s), .afull_n(af_s),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en_n(ren_s), .oe_n(oe_n),
    .rd_data(data_s), .rd_data_en(den_s), .emp_ordy_n(emp_s), .aempty_n(ae_s)
  );

  dc_fifo18 #(.DEPTH(DEPTH), .MODE(dcf_pkg::PRES_FWFT)) u_dc_fifo18_fwft (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
    .wr_data(wr_data), .full_irdy_n(full_f), .half_n(half_f), .afull_n(af_f),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en_n(ren_f), .oe_n(oe_n),
    .rd_data(data_f), .rd_data_en(den_f), .emp_ordy_n(emp_f), .aempty_n(ae_f)
  );

  // Reference model, index 0 = standard, 1 = fall-through
  int          wc[2], rc[2], wd1[2], wd2[2], rd1[2], rd2[2], ae[2], af[2];
  bit          of[2], sel[2];
  logic [17:0] outv[2];
  logic [17:0] qs[$];
  logic [17:0] qf[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int d = 0; d < 2; d++) begin
      wc[d] = 0; rc[d] = 0; wd1[d] = 0; wd2[d] = 0; rd1[d] = 0; rd2[d] = 0;
      ae[d] = 7; af[d] = 7; of[d] = 0; sel[d] = 0; outv[d] = '0;
    end
    qs.delete();
    qf.delete();
  endtask

  task automatic mdl_edge(int d, logic ren);
    int  cw, cr, nwc, nrc;
    bit  fl, rq, cons;
    logic [17:0] v;
    cw = wc[d] - rd2[d];
    cr = wd2[d] - rc[d];
    fl = (cw == DEPTH);
    nwc = wc[d];
    nrc = rc[d];
    if (!load_n) begin
      if (!wr_en_n) begin
        if (!sel[d]) ae[d] = int'(wr_data[AW-1:0]);
        else         af[d] = int'(wr_data[AW-1:0]);
        sel[d] = !sel[d];
      end
    end else begin
      sel[d] = 0;
      if (!wr_en_n && !fl) begin
        if (d == 0) qs.push_back(wr_data); else qf.push_back(wr_data);
        nwc++;
      end
    end
    rq = !ren && !oe_n;
    if (d == 0) begin
      if (rq && cr > 0) begin
        v = qs.pop_front();
        outv[d] = v;
        nrc++;
      end
    end else begin
      cons = of[d] && rq;
      if (cr > 0 && (!of[d] || cons)) begin
        v = qf.pop_front();
        outv[d] = v;
        nrc++;
        of[d] = 1;
      end else if (cons) begin
        of[d] = 0;
      end
    end
    wd2[d] = wd1[d]; wd1[d] = wc[d]; wc[d] = nwc;
    rd2[d] = rd1[d]; rd1[d] = rc[d]; rc[d] = nrc;
  endtask

  task automatic cmp(int d, logic emp, logic full, logic half, logic aen,
                     logic afn, logic [17:0] dat, logic den);
    int cw, cr, occ;
    cw  = wc[d] - rd2[d];
    cr  = wd2[d] - rc[d];
    occ = cr + ((d == 1) ? int'(of[d]) : 0);
    chk("R1", (d == 0) ? "std rd_data" : "fwft rd_data", int'(dat),
        oe_n ? 0 : int'(outv[d]));
    chk("R4", "rd_data_en", int'(den), int'(!oe_n));
    if (d == 0) chk("R5", "std emp_ordy_n", int'(emp), int'(cr != 0));
    else        chk("R6", "fwft emp_ordy_n", int'(emp), int'(!of[d]));
    chk("R7", "full_irdy_n", int'(full), (d == 1) ? int'(cw == DEPTH) : int'(cw != DEPTH));
    chk("R8", "half_n", int'(half), int'(!(cw > DEPTH / 2)));
    chk("R9", "afull_n", int'(afn), int'(!(cw >= DEPTH - af[d])));
    chk("R9", "aempty_n", int'(aen), int'(!(occ <= ae[d])));
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst_n) begin
      mdl_reset();
    end else begin
      mdl_edge(0, ren_s);
      mdl_edge(1, ren_f);
      cmp(0, emp_s, full_s, half_s, ae_s, af_s, data_s, den_s);
      cmp(1, emp_f, full_f, half_f, ae_f, af_f, data_f, den_f);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write1(logic [17:0] v);
    wr_en_n = 1'b0; wr_data = v; step(); wr_en_n = 1'b1;
  endtask

  task automatic pump(int n, bit wheavy);
    logic [31:0] lf;
    logic [17:0] cntr;
    lf = 32'h1ACE_B00C;
    cntr = wheavy ? 18'h01000 : 18'h03000;
    for (int i = 0; i < n; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wr_data = cntr;
      cntr = cntr + 18'd1;
      if (wheavy) begin
        wr_en_n = (lf[1:0] == 2'b00);
        ren_s   = (lf[3:2] != 2'b00);
        ren_f   = (lf[5:4] != 2'b00);
      end else begin
        wr_en_n = (lf[1:0] != 2'b00);
        ren_s   = (lf[3:2] == 2'b00);
        ren_f   = (lf[5:4] == 2'b00);
      end
      oe_n = (lf[9:6] == 4'b0000);
      step();
    end
    wr_en_n = 1'b1; ren_s = 1'b1; ren_f = 1'b1; oe_n = 1'b0;
  endtask

  task automatic drain(int n);
    ren_s = 1'b0; ren_f = 1'b0;
    idle(n);
    ren_s = 1'b1; ren_f = 1'b1;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0; wr_en_n = 1'b1; load_n = 1'b1; oe_n = 1'b0;
    ren_s = 1'b1; ren_f = 1'b1; wr_data = '0;
    idle(3);
    // R11 reset state
    chk("R11", "std emp_ordy_n", int'(emp_s), 0);
    chk("R11", "fwft emp_ordy_n", int'(emp_f), 1);
    chk("R11", "std full_irdy_n", int'(full_s), 1);
    chk("R11", "fwft full_irdy_n", int'(full_f), 0);
    chk("R11", "half_n", int'(half_s & half_f), 1);
    chk("R11", "aempty_n", int'(ae_s | ae_f), 0);
    chk("R11", "afull_n", int'(af_s & af_f), 1);
    chk("R11", "rd_data", int'(data_s | data_f), 0);
    rst_n = 1'b1;
    idle(2);

    // R6 / R5 first-word latency
    write1(18'h2A5A5);
    step();
    chk("R6", "fwft ready after 1 edge", int'(emp_f), 1);
    step();
    chk("R6", "fwft ready after 2 edges", int'(emp_f), 1);
    chk("R5", "std not empty after 2 edges", int'(emp_s), 1);
    chk("R5", "std data before read", int'(data_s), 0);
    step();
    chk("R6", "fwft ready after 3 edges", int'(emp_f), 0);
    chk("R6", "fwft first word", int'(data_f), 'h2A5A5);
    chk("R5", "std data still held", int'(data_s), 0);
    ren_s = 1'b0; ren_f = 1'b0; step(); ren_s = 1'b1; ren_f = 1'b1;
    chk("R5", "std word after read", int'(data_s), 'h2A5A5);
    chk("R6", "fwft consumed", int'(emp_f), 1);

    // R4 / R3 output enable blocks reads
    write1(18'h11111);
    write1(18'h22222);
    idle(4);
    oe_n = 1'b1; ren_s = 1'b0; ren_f = 1'b0;
    idle(4);
    chk("R4", "std rd_data gated", int'(data_s), 0);
    chk("R4", "fwft rd_data_en", int'(den_f), 0);
    chk("R3", "std still holds words", int'(emp_s), 1);
    ren_s = 1'b1; ren_f = 1'b1; oe_n = 1'b0;
    step();
    chk("R4", "fwft word back after oe", int'(data_f), 'h11111);
    chk("R4", "std old word back", int'(data_s), 'h2A5A5);
    drain(3);
    // R3 read while empty ignored
    ren_s = 1'b0; ren_f = 1'b0;
    idle(4);
    ren_s = 1'b1; ren_f = 1'b1;
    write1(18'h33333);
    idle(4);
    chk("R3", "fwft shows new word", int'(data_f), 'h33333);
    ren_s = 1'b0; ren_f = 1'b0; step(); ren_s = 1'b1; ren_f = 1'b1;
    chk("R3", "std reads new word", int'(data_s), 'h33333);
    idle(3);

    // Streaming with overrun and underrun
    pump(700, 1'b1);
    pump(900, 1'b0);
    drain(DEPTH + 20);

    // R10 offset load: ae=3, af=5
    load_n = 1'b0; wr_en_n = 1'b0; wr_data = 18'd3; step();
    wr_data = 18'd5; step();
    wr_en_n = 1'b1; load_n = 1'b1;
    idle(4);
    chk("R10", "load stores no word", int'(emp_s), 0);
    for (int i = 0; i < 3; i++) write1(18'h00100 + 18'(i));
    idle(5);
    chk("R10", "std aempty at 3", int'(ae_s), 0);
    chk("R10", "fwft aempty at 3", int'(ae_f), 0);
    write1(18'h00103);
    idle(5);
    chk("R10", "std aempty at 4", int'(ae_s), 1);
    chk("R10", "fwft aempty at 4", int'(ae_f), 1);
    for (int i = 0; i < 246; i++) write1(18'h00104 + 18'(i));
    idle(4);
    chk("R10", "std afull at 250", int'(af_s), 1);
    write1(18'h001FA);
    idle(4);
    chk("R10", "std afull at 251", int'(af_s), 0);
    drain(DEPTH + 20);

    // R2 / R7 fill past full
    for (int i = 0; i < DEPTH + 6; i++) begin
      wr_en_n = 1'b0; wr_data = 18'h20000 + 18'(i); step();
    end
    wr_en_n = 1'b1;
    idle(4);
    chk("R7", "std full", int'(full_s), 0);
    chk("R7", "fwft input not ready", int'(full_f), 1);
    chk("R8", "std half", int'(half_s), 0);
    drain(DEPTH + 10);
    chk("R2", "std last word kept", int'(data_s), 'h20000 + DEPTH - 1);
    chk("R7", "fwft extra word kept", int'(data_f), 'h20000 + DEPTH);
    chk("R2", "std empty after drain", int'(emp_s), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule